// File: doc/BRIEF.md
# Staged Interrupt Re-enable Controller

This controller sits beside a processor core that services several power-converter control loops, one service routine per rail. Each routine begins with a short, time-critical stage that computes the new duty cycle. A longer stage follows that prepares terms for the next sample. When a loop's request is accepted, the controller masks all further entries and counts retired instructions. Once the count reaches the critical length programmed for that loop, it reopens interrupts on its own. A later request from another loop can then cut into the deferred stage only, never into the duty-cycle computation.

Software writes a critical length for each loop through a small address/data write port. The controller keeps requests that arrive while entry is masked, and accepts the lowest-numbered waiting loop first. Each loop can be nested at most once. When a routine is preempted, the controller saves the program counter and the progress of that routine in a slot belonging to the preempted loop. When the preempting routine returns, it restores that state and reports the address to resume at.

Top module: `staged_irq_ctrl`

## Requirements
- R1: After reset, busy_o is 0, open_o is 1, take_o is 0 and resume_o is 0. Each loop's critical length starts at RST_LEN, which is 4 by default.
- R2: A one-cycle request on bit k of irq_i is sampled at a clock edge. When no routine is running, take_o is high for exactly one cycle from the next edge. In that cycle loop_o equals k and vec_o equals VEC_BASE + k*VEC_STRIDE (0x40 + k*0x10 by default).
- R3: When several loops are waiting and entry is allowed, the one with the lowest index is accepted first.
- R4: On entry to loop k, open_o drops to 0. It returns to 1 at the edge that samples the L-th retire_i strobe after entry, where L is loop k's critical length. If L is 0, open_o is already 1 in the cycle take_o is high.
- R5: While open_o is 0, no entry happens. Requests that arrive then are kept and accepted once open_o returns to 1.
- R6: While a routine runs with open_o at 1, a waiting request from a different loop preempts it, and take_o reports the new loop.
- R7: A return strobe (rti_i) while a preempting routine runs does the following. From the next edge, resume_o is high for one cycle, ret_addr_o holds the pc_i value sampled when the preemption was accepted, loop_o shows the preempted loop again, and open_o is 1.
- R8: A return strobe from a routine that preempted nothing ends service: busy_o drops to 0, open_o is 1 and resume_o stays 0.
- R9: A write with cfg_we_i high stores cfg_data_i as the critical length of loop cfg_addr_i. A write to an address at or above N_LOOPS changes nothing.
- R10: A loop's own request that arrives while its routine is running or preempted is not accepted then. It is accepted after that routine has returned.
- R11: Preemptions can stack until every loop is in use. Successive returns unwind them in reverse order, each resuming at its own saved address.
- R12: retire_i and rti_i have no effect while no routine is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_LOOPS | One request strobe per control loop |
| retire_i | input | 1 | One instruction retired this cycle |
| pc_i | input | PC_W | Address the core would execute next |
| rti_i | input | 1 | Return-from-interrupt strobe |
| cfg_we_i | input | 1 | Critical-length write enable |
| cfg_addr_i | input | IDX_W | Loop index of the write |
| cfg_data_i | input | CNT_W | Critical length in instructions |
| take_o | output | 1 | One-cycle vector request to the core |
| vec_o | output | PC_W | Entry address for the accepted loop |
| loop_o | output | IDX_W | Loop whose routine is running |
| busy_o | output | 1 | A routine is running |
| open_o | output | 1 | Entry of another routine is allowed |
| resume_o | output | 1 | One-cycle strobe: resume a preempted routine |
| ret_addr_o | output | PC_W | Address to resume at, valid with resume_o |

## Verification
The properties assume that the core pulses rti_i only while a routine runs, and only after the core has acted on take_o. They also assume retire_i describes the routine that loop_o reports. The stimulus follows the same order: it waits for take_o before it pulses retire_i or rti_i, and it issues exactly one return per accepted entry. It keeps pc_i steady while a preemption may be accepted. The random part draws loop pairs and critical lengths from 0 to 6 with a fixed seed. The directed part covers length zero, a write to an address out of range, self-requests, simultaneous requests and a nesting three loops deep.

// File: rtl/sirc_pkg.sv
package sirc_pkg;

   // what the controller does at the coming edge
   typedef enum logic [1:0] {
      EV_IDLE   = 2'd0,
      EV_ENTER  = 2'd1,
      EV_RESUME = 2'd2,
      EV_FINISH = 2'd3
   } sirc_ev_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sirc_pend.sv
// Pending-request latch with lowest-index-first selection
module sirc_pend #(
   parameter int unsigned N  = 3,
   parameter int unsigned IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_i,
   input  logic          clr_i,
   input  logic [IW-1:0] clr_idx_i,
   input  logic [N-1:0]  busy_mask_i,
   output logic          any_o,
   output logic [IW-1:0] pick_o
);
   logic [N-1:0] pend_q;
   logic [N-1:0] clr_vec;
   logic [N-1:0] elig;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_bit
         assign clr_vec[g] = clr_i && (clr_idx_i == IW'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= (pend_q[g] & ~clr_vec[g]) | req_i[g];
         end
      end
   endgenerate

   assign elig  = pend_q & ~busy_mask_i;
   assign any_o = |elig;

   always_comb begin
      pick_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig[i]) pick_o = IW'(i);
      end
   end
endmodule

// File: rtl/sirc_lenreg.sv
// Per-loop critical-stage length registers, one write port, two read ports
module sirc_lenreg #(
   parameter int unsigned N       = 3,
   parameter int unsigned IW      = 2,
   parameter int unsigned CW      = 8,
   parameter int unsigned RST_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [IW-1:0] addr_i,
   input  logic [CW-1:0] data_i,
   input  logic [IW-1:0] rd_a_i,
   input  logic [IW-1:0] rd_b_i,
   output logic [CW-1:0] len_a_o,
   output logic [CW-1:0] len_b_o
);
   logic [CW-1:0] len_q [N];

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_len
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               len_q[g] <= CW'(RST_LEN);
            else if (we_i && (addr_i == IW'(g)))
               len_q[g] <= data_i;
         end
      end
   endgenerate

   always_comb begin
      len_a_o = '0;
      len_b_o = '0;
      for (int i = 0; i < N; i++) begin
         if (rd_a_i == IW'(i)) len_a_o = len_q[i];
         if (rd_b_i == IW'(i)) len_b_o = len_q[i];
      end
   end
endmodule

// File: rtl/sirc_ctx.sv
// Per-loop saved context and the link to the routine each loop preempted
module sirc_ctx #(
   parameter int unsigned N  = 3,
   parameter int unsigned IW = 2,
   parameter int unsigned PW = 16,
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          save_i,
   input  logic [IW-1:0] save_idx_i,
   input  logic [PW-1:0] save_pc_i,
   input  logic [CW-1:0] save_cnt_i,
   input  logic          save_open_i,
   input  logic          link_i,
   input  logic [IW-1:0] link_idx_i,
   input  logic [IW-1:0] link_par_i,
   input  logic          link_valid_i,
   input  logic [IW-1:0] cur_idx_i,
   output logic          has_par_o,
   output logic [IW-1:0] par_idx_o,
   output logic [PW-1:0] par_pc_o,
   output logic [CW-1:0] par_cnt_o,
   output logic          par_open_o
);
   typedef struct packed {
      logic [PW-1:0] pc;
      logic [CW-1:0] cnt;
      logic          open;
   } ctx_t;

   ctx_t          ctx_q  [N];
   logic [IW-1:0] par_q  [N];
   logic          hpar_q [N];

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctx_q[g] <= '0;
            end else if (save_i && (save_idx_i == IW'(g))) begin
               ctx_q[g].pc   <= save_pc_i;
               ctx_q[g].cnt  <= save_cnt_i;
               ctx_q[g].open <= save_open_i;
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               par_q[g]  <= '0;
               hpar_q[g] <= 1'b0;
            end else if (link_i && (link_idx_i == IW'(g))) begin
               par_q[g]  <= link_par_i;
               hpar_q[g] <= link_valid_i;
            end
         end
      end
   endgenerate

   ctx_t par_ctx;

   always_comb begin
      has_par_o = 1'b0;
      par_idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (cur_idx_i == IW'(i)) begin
            has_par_o = hpar_q[i];
            par_idx_o = par_q[i];
         end
      end
      par_ctx = '0;
      for (int i = 0; i < N; i++) begin
         if (par_idx_o == IW'(i)) par_ctx = ctx_q[i];
      end
   end

   assign par_pc_o   = par_ctx.pc;
   assign par_cnt_o  = par_ctx.cnt;
   assign par_open_o = par_ctx.open;
endmodule

// File: rtl/staged_irq_ctrl.sv
module staged_irq_ctrl #(
   parameter int unsigned     N_LOOPS    = 3,
   parameter int unsigned     PC_W       = 16,
   parameter int unsigned     CNT_W      = 8,
   parameter int unsigned     RST_LEN    = 4,
   parameter logic [PC_W-1:0] VEC_BASE   = 'h40,
   parameter logic [PC_W-1:0] VEC_STRIDE = 'h10,
   localparam int unsigned    IDX_W      = sirc_pkg::idx_bits(N_LOOPS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LOOPS-1:0] irq_i,
   input  logic               retire_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic               rti_i,
   input  logic               cfg_we_i,
   input  logic [IDX_W-1:0]   cfg_addr_i,
   input  logic [CNT_W-1:0]   cfg_data_i,
   output logic               take_o,
   output logic [PC_W-1:0]    vec_o,
   output logic [IDX_W-1:0]   loop_o,
   output logic               busy_o,
   output logic               open_o,
   output logic               resume_o,
   output logic [PC_W-1:0]    ret_addr_o
);
   import sirc_pkg::*;

   initial begin : param_chk
      assert (N_LOOPS >= 2) else $error("N_LOOPS must be at least 2");
      assert (CNT_W >= 1 && CNT_W <= 16) else $error("CNT_W out of range");
      assert (RST_LEN < (1 << CNT_W)) else $error("RST_LEN does not fit CNT_W");
      assert (PC_W >= 4) else $error("PC_W too small");
   end

   logic               busy_q, open_q, take_q, resume_q;
   logic [IDX_W-1:0]   act_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [N_LOOPS-1:0] inuse_q;
   logic [PC_W-1:0]    vec_q, ret_q;

   logic               any_elig;
   logic [IDX_W-1:0]   pick;
   logic [CNT_W-1:0]   len_pick, len_act;
   logic               has_par, par_open;
   logic [IDX_W-1:0]   par_idx;
   logic [PC_W-1:0]    par_pc;
   logic [CNT_W-1:0]   par_cnt;
   sirc_ev_e           ev;
   logic [N_LOOPS-1:0] pick_oh, act_oh;
   logic [CNT_W:0]     cnt_nxt;

   // event selection: a return wins over a new entry in the same cycle
   always_comb begin
      ev = EV_IDLE;
      if (rti_i && busy_q)
         ev = has_par ? EV_RESUME : EV_FINISH;
      else if (any_elig && (!busy_q || open_q))
         ev = EV_ENTER;
   end

   assign pick_oh = N_LOOPS'(1) << pick;
   assign act_oh  = N_LOOPS'(1) << act_q;
   assign cnt_nxt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

   sirc_pend #(.N(N_LOOPS), .IW(IDX_W)) u_pend (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (irq_i),
      .clr_i       (ev == EV_ENTER),
      .clr_idx_i   (pick),
      .busy_mask_i (inuse_q),
      .any_o       (any_elig),
      .pick_o      (pick)
   );

   sirc_lenreg #(.N(N_LOOPS), .IW(IDX_W), .CW(CNT_W), .RST_LEN(RST_LEN)) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .addr_i  (cfg_addr_i),
      .data_i  (cfg_data_i),
      .rd_a_i  (pick),
      .rd_b_i  (act_q),
      .len_a_o (len_pick),
      .len_b_o (len_act)
   );

   sirc_ctx #(.N(N_LOOPS), .IW(IDX_W), .PW(PC_W), .CW(CNT_W)) u_ctx (
      .clk          (clk),
      .rst_n        (rst_n),
      .save_i       ((ev == EV_ENTER) && busy_q),
      .save_idx_i   (act_q),
      .save_pc_i    (pc_i),
      .save_cnt_i   (cnt_q),
      .save_open_i  (open_q),
      .link_i       (ev == EV_ENTER),
      .link_idx_i   (pick),
      .link_par_i   (act_q),
      .link_valid_i (busy_q),
      .cur_idx_i    (act_q),
      .has_par_o    (has_par),
      .par_idx_o    (par_idx),
      .par_pc_o     (par_pc),
      .par_cnt_o    (par_cnt),
      .par_open_o   (par_open)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         open_q   <= 1'b1;
         act_q    <= '0;
         cnt_q    <= '0;
         inuse_q  <= '0;
         take_q   <= 1'b0;
         resume_q <= 1'b0;
         vec_q    <= '0;
         ret_q    <= '0;
      end else begin
         take_q   <= (ev == EV_ENTER);
         resume_q <= (ev == EV_RESUME);
         unique case (ev)
            EV_ENTER: begin
               busy_q  <= 1'b1;
               act_q   <= pick;
               cnt_q   <= '0;
               open_q  <= (len_pick == '0);
               inuse_q <= inuse_q | pick_oh;
               vec_q   <= VEC_BASE + PC_W'(pick) * VEC_STRIDE;
            end
            EV_RESUME: begin
               act_q   <= par_idx;
               cnt_q   <= par_cnt;
               open_q  <= par_open;
               inuse_q <= inuse_q & ~act_oh;
               ret_q   <= par_pc;
            end
            EV_FINISH: begin
               busy_q  <= 1'b0;
               open_q  <= 1'b1;
               cnt_q   <= '0;
               inuse_q <= inuse_q & ~act_oh;
            end
            default: begin
               if (busy_q && !open_q && retire_i) begin
                  cnt_q <= cnt_nxt[CNT_W-1:0];
                  if (cnt_nxt >= {1'b0, len_act}) open_q <= 1'b1;
               end
            end
         endcase
      end
   end

   assign take_o     = take_q;
   assign vec_o      = vec_q;
   assign loop_o     = act_q;
   assign busy_o     = busy_q;
   assign open_o     = open_q;
   assign resume_o   = resume_q;
   assign ret_addr_o = ret_q;
endmodule

// File: rtl/staged_irq_ctrl_chk.sv
module staged_irq_ctrl_chk #(
   parameter int unsigned     N_LOOPS    = 3,
   parameter int unsigned     PC_W       = 16,
   parameter logic [PC_W-1:0] VEC_BASE   = 'h40,
   parameter logic [PC_W-1:0] VEC_STRIDE = 'h10,
   localparam int unsigned    IDX_W      = sirc_pkg::idx_bits(N_LOOPS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             retire_i,
   input logic             take_o,
   input logic [PC_W-1:0]  vec_o,
   input logic [IDX_W-1:0] loop_o,
   input logic             busy_o,
   input logic             open_o,
   input logic             resume_o
);
   // R2
   vec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (vec_o == VEC_BASE + PC_W'(loop_o) * VEC_STRIDE) && busy_o);

   // R4
   reopen_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $rose(open_o) && !take_o && !resume_o) |-> $past(retire_i));

   // R5
   entry_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (!$past(busy_o) || $past(open_o)));

   // R7
   resume_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> busy_o && open_o && !take_o);

   // R8
   idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> open_o && !resume_o);
endmodule

bind staged_irq_ctrl staged_irq_ctrl_chk #(
   .N_LOOPS(N_LOOPS), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .take_o(take_o), .vec_o(vec_o),
   .loop_o(loop_o), .busy_o(busy_o), .open_o(open_o), .resume_o(resume_o)
);

// File: tb/staged_irq_ctrl_test.sv
module staged_irq_ctrl_test;
   localparam int N = 3, PW = 16, CW = 8, IW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_i = '0;
   logic          retire_i = 1'b0, rti_i = 1'b0, cfg_we_i = 1'b0;
   logic [PW-1:0] pc_i = '0;
   logic [IW-1:0] cfg_addr_i = '0;
   logic [CW-1:0] cfg_data_i = '0;
   logic          take_o, busy_o, open_o, resume_o;
   logic [PW-1:0] vec_o, ret_addr_o;
   logic [IW-1:0] loop_o;

   int total = 0, bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   staged_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .retire_i(retire_i), .pc_i(pc_i),
      .rti_i(rti_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
      .take_o(take_o), .vec_o(vec_o), .loop_o(loop_o), .busy_o(busy_o), .open_o(open_o),
      .resume_o(resume_o), .ret_addr_o(ret_addr_o)
   );

   function automatic int vec_of(input int k);
      return 'h40 + k * 'h10;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic pulse_irq(input logic [N-1:0] v);
      irq_i = v; tick(); irq_i = '0;
   endtask

   task automatic retire(input int n);
      for (int i = 0; i < n; i++) begin
         retire_i = 1'b1; tick(); retire_i = 1'b0;
      end
   endtask

   task automatic do_rti();
      rti_i = 1'b1; tick(); rti_i = 1'b0;
   endtask

   task automatic cfg(input int a, input int d);
      cfg_we_i = 1'b1; cfg_addr_i = IW'(a); cfg_data_i = CW'(d);
      tick(); cfg_we_i = 1'b0;
   endtask

   task automatic wait_take(input int lim, input string req);
      bit seen = 0;
      for (int i = 0; i < lim && !seen; i++) begin
         tick();
         if (take_o) seen = 1;
      end
      chk({req, " take seen"}, int'(seen), 1);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin : main
      int a, b, la, lb, pcv;
      void'($urandom(32'd2024));
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 busy", busy_o, 0);
      chk("R1 open", open_o, 1);
      chk("R1 take", take_o, 0);
      chk("R1 resume", resume_o, 0);

      // R1 default length 4 on loop 1
      pulse_irq(3'b010);
      wait_take(3, "R1");
      retire(3);
      chk("R1 still masked at 3", open_o, 0);
      retire(1);
      chk("R1 open at 4", open_o, 1);
      do_rti();

      // R9 program lengths
      cfg(0, 3); cfg(1, 2); cfg(2, 5);

      // R2 timing and vector
      pulse_irq(3'b010);
      chk("R2 no take in decision cycle", take_o, 0);
      tick();
      chk("R2 take", take_o, 1);
      chk("R2 loop", loop_o, 1);
      chk("R2 vec", vec_o, vec_of(1));
      chk("R4 masked on entry", open_o, 0);
      tick();
      chk("R2 take one cycle", take_o, 0);
      retire(1);
      chk("R4 masked after 1 of 2", open_o, 0);
      retire(1);
      chk("R4 open after 2", open_o, 1);
      do_rti();
      chk("R8 idle", busy_o, 0);
      chk("R8 no resume", resume_o, 0);
      chk("R8 open", open_o, 1);

      // R3 simultaneous, R5 hold while masked, R6/R7 preempt and resume
      pc_i = 16'h1234;
      pulse_irq(3'b101);
      wait_take(3, "R3");
      chk("R3 lowest wins", loop_o, 0);
      for (int i = 0; i < 5; i++) begin
         tick();
         chk("R5 no entry while masked", take_o, 0);
      end
      retire(3);
      chk("R4 loop0 open", open_o, 1);
      wait_take(3, "R6");
      chk("R6 preempting loop", loop_o, 2);
      chk("R6 vec", vec_o, vec_of(2));
      retire(5);
      do_rti();
      chk("R7 resume", resume_o, 1);
      chk("R7 ret addr", ret_addr_o, 'h1234);
      chk("R7 loop back", loop_o, 0);
      chk("R7 open", open_o, 1);
      do_rti();
      chk("R8 idle after unwind", busy_o, 0);

      // R10 own request held until return
      pulse_irq(3'b010);
      wait_take(3, "R10");
      retire(2);
      pulse_irq(3'b010);
      for (int i = 0; i < 6; i++) begin
         tick();
         chk("R10 no self preempt", take_o, 0);
      end
      do_rti();
      chk("R10 idle", busy_o, 0);
      wait_take(3, "R10 after return");
      chk("R10 loop", loop_o, 1);
      retire(2);
      do_rti();

      // R4 zero length
      cfg(2, 0);
      pulse_irq(3'b100);
      wait_take(3, "R4 zero");
      chk("R4 zero length open at entry", open_o, 1);
      do_rti();

      // R9 out-of-range write ignored
      cfg(3, 0);
      pulse_irq(3'b001);
      wait_take(3, "R9");
      chk("R9 loop0 length unchanged", open_o, 0);
      retire(3);
      chk("R9 loop0 open after 3", open_o, 1);
      do_rti();

      // R11 three-deep nesting
      cfg(0, 1); cfg(1, 1); cfg(2, 2);
      pc_i = 16'h0AAA;
      pulse_irq(3'b100);
      wait_take(3, "R11 outer");
      retire(2);
      pulse_irq(3'b010);
      wait_take(3, "R11 mid");
      chk("R11 mid loop", loop_o, 1);
      pc_i = 16'h0BBB;
      retire(1);
      pulse_irq(3'b001);
      wait_take(3, "R11 inner");
      chk("R11 inner loop", loop_o, 0);
      retire(1);
      do_rti();
      chk("R11 first resume", resume_o, 1);
      chk("R11 first addr", ret_addr_o, 'h0BBB);
      chk("R11 first loop", loop_o, 1);
      do_rti();
      chk("R11 second resume", resume_o, 1);
      chk("R11 second addr", ret_addr_o, 'h0AAA);
      chk("R11 second loop", loop_o, 2);
      do_rti();
      chk("R11 done", busy_o, 0);

      // R12 strobes while idle
      retire(3);
      do_rti();
      chk("R12 busy", busy_o, 0);
      chk("R12 open", open_o, 1);
      chk("R12 resume", resume_o, 0);
      tick();
      chk("R12 take", take_o, 0);

      // random pairs
      for (int it = 0; it < 40; it++) begin
         a   = int'($urandom_range(0, 2));
         b   = (a + 1 + int'($urandom_range(0, 1))) % 3;
         la  = int'($urandom_range(0, 6));
         lb  = int'($urandom_range(0, 6));
         pcv = int'($urandom_range(0, 65535));
         cfg(a, la); cfg(b, lb);
         pc_i = PW'(pcv);
         pulse_irq(N'(1) << a);
         wait_take(3, "R2 rnd");
         chk("R2 rnd loop", loop_o, a);
         chk("R2 rnd vec", vec_o, vec_of(a));
         chk("R4 rnd entry open", open_o, (la == 0) ? 1 : 0);
         pulse_irq(N'(1) << b);
         for (int i = 0; i < la; i++) begin
            chk("R5 rnd held", take_o, 0);
            retire(1);
         end
         chk("R4 rnd open", open_o, 1);
         wait_take(4, "R6 rnd");
         chk("R6 rnd loop", loop_o, b);
         retire(lb);
         do_rti();
         chk("R7 rnd resume", resume_o, 1);
         chk("R7 rnd addr", ret_addr_o, pcv);
         chk("R7 rnd loop", loop_o, a);
         do_rti();
         chk("R8 rnd idle", busy_o, 0);
      end

      done = 1;
      summary();
      $finish;
   end
endmodule